// File: doc/BRIEF.md
# DMA End-of-Process Detector

This block watches the active-low DMA handshake lines of a bus controller and decides when an end-of-process indication is genuine. The indication counts only while DMA mode is on, and only when the end-of-process line, the DMA acknowledge and at least one of the read or write strobes have all been low together for a minimum window (100 ns by default). The window is measured in clock cycles after a two-stage synchroniser. A qualified indication sets a sticky End of DMA flag. When the end-of-process interrupt enable is set, it also latches an interrupt.

The block also builds the 8-bit bus-and-status byte. The End of DMA flag and the interrupt-active bit come from its own state. The other six bits are status flags that neighbouring logic supplies. The interrupt request line is the OR of the latched end-of-process cause and an input that carries every other enabled, latched cause. A one-cycle clear pulse drops both latched items.

Top module: `dma_eop_detect`

## Requirements
- R1: While reset is high, and on the first cycle after it, bus_status[7] and irq read 0; with all status inputs low, bus_status reads 8'h00.
- R2: Suppose the end-of-process, acknowledge and read lines go low just after clock edge t0 and stay low for MIN_CYC cycles, where MIN_CYC = ceil(MIN_OVERLAP_PS / CLK_PERIOD_PS) (25 by default). Then bus_status[7] reads 1 after edge t0+2+MIN_CYC, and not earlier.
- R3: An overlap that lasts MIN_CYC-1 cycles does not set bus_status[7]. An end-of-process pulse without the acknowledge, or without either strobe, does not set it either, however long it lasts.
- R4: While the DMA mode input is low, no overlap of any length sets bus_status[7].
- R5: bus_status[7] stays at 1 until a cycle with clr_irq high, and reads 0 after that edge. When a qualifying overlap completes on the same edge as clr_irq, the set wins.
- R6: A single unbroken overlap sets bus_status[7] at most once. If the flag is cleared while the overlap continues, it stays 0 until the lines are released and a new overlap qualifies.
- R7: The end-of-process interrupt latches only if eop_irq_en is high on the edge where the flag is set. A flag set while the enable is low raises no interrupt, even if the enable is raised later. clr_irq clears the latched interrupt.
- R8: irq is the OR of the latched end-of-process interrupt and other_irq_in, and bus_status[4] always equals irq.
- R9: The remaining bits of bus_status follow their inputs in the same cycle: bit 6 DMA request, bit 5 parity error, bit 3 phase match, bit 2 busy error, bit 1 ATN, bit 0 ACK.
- R10: The write strobe qualifies exactly as the read strobe does. The timing of R2 applies when iow_n is low in place of ior_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eop_n | input | 1 | End-of-process, active low, asynchronous |
| dack_n | input | 1 | DMA acknowledge, active low, asynchronous |
| ior_n | input | 1 | Read strobe, active low, asynchronous |
| iow_n | input | 1 | Write strobe, active low, asynchronous |
| dma_mode | input | 1 | DMA mode bit from the mode register |
| eop_irq_en | input | 1 | End-of-process interrupt enable from the mode register |
| clr_irq | input | 1 | One-cycle clear of the flag and the latched interrupt |
| drq_in | input | 1 | DMA request status flag |
| parity_err_in | input | 1 | Parity error status flag |
| phase_match_in | input | 1 | Phase match status flag |
| busy_err_in | input | 1 | Busy error status flag |
| atn_in | input | 1 | ATN line status |
| ack_in | input | 1 | ACK line status |
| other_irq_in | input | 1 | OR of the other enabled, latched interrupt causes |
| bus_status | output | 8 | Assembled bus-and-status byte |
| irq | output | 1 | Interrupt request |

## Verification
A wrong synchroniser depth or a counter that is off by one shows up at bus_status[7]: the bit rises one cycle early or late, or a pulse one cycle too short still sets it. A latch that does not hold or does not clear shows in the first cycle after the clear pulse, or after the edge that should have held it. The bench compares the whole status byte and irq against a behavioural model on every clock, so any such divergence shows up within one cycle of the edge where it starts.

// File: rtl/dma_eop_pkg.sv
`timescale 1ns/1ps
package dma_eop_pkg;

    // Bus-and-status byte, most significant bit first.
    typedef struct packed {
        logic end_dma;
        logic dma_req;
        logic parity_err;
        logic irq_active;
        logic phase_match;
        logic busy_err;
        logic atn;
        logic ack;
    } bsr_t;

    // Handshake lines after synchronisation, active high.
    typedef struct packed {
        logic eop;
        logic dack;
        logic rd;
        logic wr;
    } hs_t;

    localparam int HS_W = 4;

    // Cycles needed to cover a window, rounded up so the window is never short.
    function automatic int min_cycles(int window_ps, int period_ps);
        int c;
        c = (window_ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic logic overlap_ok(hs_t h, logic mode);
        return mode & h.eop & h.dack & (h.rd | h.wr);
    endfunction

endpackage

// File: rtl/eop_sync.sv
`timescale 1ns/1ps
module eop_sync #(
    parameter int   W      = 4,
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES+1];

    assign stg[0] = din;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg[g+1] <= {W{IDLE}};
            end else begin
                stg[g+1] <= stg[g];
            end
        end
    end

    assign dout = stg[STAGES];
endmodule

// File: rtl/eop_qualifier.sv
`timescale 1ns/1ps
module eop_qualifier
    import dma_eop_pkg::*;
#(
    parameter int MIN_CYC = 25
) (
    input  logic clk,
    input  logic rst,
    input  hs_t  hs,
    input  logic dma_mode,
    output logic fire
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);
    localparam logic [CW-1:0] SAT  = CW'(MIN_CYC);

    logic          ov;
    logic [CW-1:0] run_q;

    assign ov   = overlap_ok(hs, dma_mode);
    // The counter saturates past LAST, so one overlap fires once only.
    assign fire = ov && (run_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (!ov) begin
            run_q <= '0;
        end else if (run_q != SAT) begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/eop_status_latch.sv
`timescale 1ns/1ps
module eop_status_latch (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic clr,
    input  logic irq_en,
    output logic end_dma,
    output logic eop_irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            end_dma <= 1'b0;
            eop_irq <= 1'b0;
        end else begin
            if (fire) begin
                end_dma <= 1'b1;
            end else if (clr) begin
                end_dma <= 1'b0;
            end
            if (fire && irq_en) begin
                eop_irq <= 1'b1;
            end else if (clr) begin
                eop_irq <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dma_eop_detect.sv
`timescale 1ns/1ps
module dma_eop_detect
    import dma_eop_pkg::*;
#(
    parameter int CLK_PERIOD_PS  = 4000,
    parameter int MIN_OVERLAP_PS = 100000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       eop_n,
    input  logic       dack_n,
    input  logic       ior_n,
    input  logic       iow_n,
    input  logic       dma_mode,
    input  logic       eop_irq_en,
    input  logic       clr_irq,
    input  logic       drq_in,
    input  logic       parity_err_in,
    input  logic       phase_match_in,
    input  logic       busy_err_in,
    input  logic       atn_in,
    input  logic       ack_in,
    input  logic       other_irq_in,
    output logic [7:0] bus_status,
    output logic       irq
);
    localparam int MIN_CYC = min_cycles(MIN_OVERLAP_PS, CLK_PERIOD_PS);

    logic [HS_W-1:0] raw_n;
    logic [HS_W-1:0] sync_n;
    hs_t             hs_act;
    logic            qual_fire;
    logic            end_dma_q;
    logic            eop_irq_q;
    bsr_t            bsr;

    assign raw_n = {eop_n, dack_n, ior_n, iow_n};

    eop_sync #(
        .W      (HS_W),
        .STAGES (SYNC_STAGES),
        .IDLE   (1'b1)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_n),
        .dout (sync_n)
    );

    assign hs_act = hs_t'(~sync_n);

    eop_qualifier #(
        .MIN_CYC (MIN_CYC)
    ) u_qual (
        .clk      (clk),
        .rst      (rst),
        .hs       (hs_act),
        .dma_mode (dma_mode),
        .fire     (qual_fire)
    );

    eop_status_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .fire    (qual_fire),
        .clr     (clr_irq),
        .irq_en  (eop_irq_en),
        .end_dma (end_dma_q),
        .eop_irq (eop_irq_q)
    );

    assign irq = eop_irq_q | other_irq_in;

    always_comb begin
        bsr             = '0;
        bsr.end_dma     = end_dma_q;
        bsr.dma_req     = drq_in;
        bsr.parity_err  = parity_err_in;
        bsr.irq_active  = irq;
        bsr.phase_match = phase_match_in;
        bsr.busy_err    = busy_err_in;
        bsr.atn         = atn_in;
        bsr.ack         = ack_in;
    end

    assign bus_status = bsr;
endmodule

// File: rtl/dma_eop_detect_chk.sv
`timescale 1ns/1ps
module dma_eop_detect_chk
    import dma_eop_pkg::*;
#(
    parameter int MIN_CYC = 25
) (
    input logic       clk,
    input logic       rst,
    input hs_t        hs,
    input logic       dma_mode,
    input logic       eop_irq_en,
    input logic       clr_irq,
    input logic       fire,
    input logic       eop_irq_q,
    input logic [7:0] bus_status
);
    int  chk_run;
    logic ov_mon;

    assign ov_mon = dma_mode & hs.eop & hs.dack & (hs.rd | hs.wr);

    // Independent run-length monitor of the synchronised overlap.
    always_ff @(posedge clk) begin
        if (rst || !ov_mon) begin
            chk_run <= 0;
        end else if (chk_run < MIN_CYC) begin
            chk_run <= chk_run + 1;
        end
    end

    p_min_overlap_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_status[7]) |-> (chk_run >= MIN_CYC));

    p_mode_gate_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_status[7]) |-> $past(dma_mode));

    p_flag_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_status[7] && !clr_irq) |=> bus_status[7]);

    p_flag_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_irq && !fire) |=> !bus_status[7]);

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(eop_irq_q) |-> ($past(eop_irq_en) && bus_status[7]));
endmodule

bind dma_eop_detect dma_eop_detect_chk #(.MIN_CYC(MIN_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hs         (hs_act),
    .dma_mode   (dma_mode),
    .eop_irq_en (eop_irq_en),
    .clr_irq    (clr_irq),
    .fire       (qual_fire),
    .eop_irq_q  (eop_irq_q),
    .bus_status (bus_status)
);

// File: tb/dma_eop_detect_test.sv
`timescale 1ns/1ps
module dma_eop_detect_test;
    localparam int PERIOD_PS = 4000;
    localparam int WIN_PS    = 100000;
    localparam int MIN       = (WIN_PS + PERIOD_PS - 1) / PERIOD_PS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic eop_n = 1'b1, dack_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1;
    logic dma_mode = 1'b0, eop_irq_en = 1'b0, clr_irq = 1'b0;
    logic drq_in = 1'b0, parity_err_in = 1'b0, phase_match_in = 1'b0;
    logic busy_err_in = 1'b0, atn_in = 1'b0, ack_in = 1'b0, other_irq_in = 1'b0;
    logic [7:0] bus_status;
    logic irq;

    int n_checks = 0;
    int n_fails  = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    dma_eop_detect #(
        .CLK_PERIOD_PS  (PERIOD_PS),
        .MIN_OVERLAP_PS (WIN_PS),
        .SYNC_STAGES    (2)
    ) uut (
        .clk(clk), .rst(rst), .eop_n(eop_n), .dack_n(dack_n), .ior_n(ior_n),
        .iow_n(iow_n), .dma_mode(dma_mode), .eop_irq_en(eop_irq_en),
        .clr_irq(clr_irq), .drq_in(drq_in), .parity_err_in(parity_err_in),
        .phase_match_in(phase_match_in), .busy_err_in(busy_err_in),
        .atn_in(atn_in), .ack_in(ack_in), .other_irq_in(other_irq_in),
        .bus_status(bus_status), .irq(irq)
    );

    // Behavioural reference model.
    logic [3:0] m_d1 = 4'hF, m_d2 = 4'hF;
    int  m_run = 0;
    bit  m_fired = 0, m_end = 0, m_irq = 0, started = 0;

    always @(posedge clk) begin
        bit ov;
        bit hit;
        logic [3:0] now;
        now = {eop_n, dack_n, ior_n, iow_n};
        started = 1;
        if (rst) begin
            m_d1 = 4'hF; m_d2 = 4'hF; m_run = 0; m_fired = 0; m_end = 0; m_irq = 0;
        end else begin
            ov  = dma_mode && !m_d2[3] && !m_d2[2] && (!m_d2[1] || !m_d2[0]);
            hit = ov && !m_fired && (m_run + 1 >= MIN);
            if (ov) begin
                m_run = m_run + 1;
                if (hit) m_fired = 1;
            end else begin
                m_run = 0;
                m_fired = 0;
            end
            if (hit) m_end = 1; else if (clr_irq) m_end = 0;
            if (hit && eop_irq_en) m_irq = 1; else if (clr_irq) m_irq = 0;
            m_d2 = m_d1;
            m_d1 = now;
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            logic [7:0] exp_bsr;
            exp_bsr = {m_end, drq_in, parity_err_in, m_irq | other_irq_in,
                       phase_match_in, busy_err_in, atn_in, ack_in};
            check({cur_req, " status byte vs model"}, bus_status, exp_bsr);
            check({cur_req, " irq vs model"}, {7'd0, irq}, {7'd0, m_irq | other_irq_in});
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic lines(bit e, bit d, bit r, bit w);
        eop_n = ~e; dack_n = ~d; ior_n = ~r; iow_n = ~w;
    endtask

    task automatic pulse(bit e, bit d, bit r, bit w, int len);
        lines(e, d, r, w);
        tick(len);
        lines(0, 0, 0, 0);
        tick(6);
    endtask

    task automatic clear_flags();
        clr_irq = 1'b1;
        tick(1);
        clr_irq = 1'b0;
        tick(1);
    endtask

    task automatic expect_bit(string tag, logic act, logic exp);
        @(negedge clk);
        check(tag, {7'd0, act}, {7'd0, exp});
        tick(1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog (all requirements): actual still running expected finished");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        tick(3);
        expect_bit("R1 reset bit7", bus_status[7], 1'b0);
        rst = 1'b0;
        expect_bit("R1 after reset status byte", bus_status == 8'h00, 1'b1);

        cur_req = "R2";
        dma_mode = 1'b1; eop_irq_en = 1'b1;
        // Exact timing: rises after edge t0+2+MIN.
        lines(1, 1, 1, 0);
        tick(MIN + 1);
        @(negedge clk);
        check("R2 bit7 still low one edge before", {7'd0, bus_status[7]}, 8'd0);
        tick(1);
        @(negedge clk);
        check("R2 bit7 set on time", {7'd0, bus_status[7]}, 8'd1);
        check("R7 irq latched when enabled", {7'd0, irq}, 8'd1);
        tick(1);
        lines(0, 0, 0, 0);
        tick(4);
        cur_req = "R5";
        expect_bit("R5 flag holds after release", bus_status[7], 1'b1);
        clear_flags();
        expect_bit("R5 flag cleared", bus_status[7], 1'b0);

        cur_req = "R3";
        pulse(1, 1, 1, 0, MIN - 1);
        expect_bit("R3 short overlap ignored", bus_status[7], 1'b0);
        pulse(1, 0, 1, 0, 3 * MIN);
        expect_bit("R3 no acknowledge ignored", bus_status[7], 1'b0);
        pulse(1, 1, 0, 0, 3 * MIN);
        expect_bit("R3 no strobe ignored", bus_status[7], 1'b0);
        pulse(1, 1, 1, 0, MIN);
        expect_bit("R3 minimum overlap accepted", bus_status[7], 1'b1);
        clear_flags();

        cur_req = "R4";
        dma_mode = 1'b0;
        pulse(1, 1, 1, 1, 3 * MIN);
        expect_bit("R4 mode off ignored", bus_status[7], 1'b0);
        dma_mode = 1'b1;

        cur_req = "R10";
        pulse(1, 1, 0, 1, MIN);
        expect_bit("R10 write strobe qualifies", bus_status[7], 1'b1);
        clear_flags();

        cur_req = "R6";
        lines(1, 1, 1, 0);
        tick(MIN + 5);
        expect_bit("R6 long overlap sets", bus_status[7], 1'b1);
        clear_flags();
        tick(40);
        expect_bit("R6 no second set in same overlap", bus_status[7], 1'b0);
        lines(0, 0, 0, 0);
        tick(5);
        pulse(1, 1, 1, 0, MIN);
        expect_bit("R6 new overlap sets again", bus_status[7], 1'b1);
        clear_flags();

        cur_req = "R5";
        lines(1, 1, 1, 0);
        tick(MIN + 1);
        clr_irq = 1'b1;
        tick(1);
        clr_irq = 1'b0;
        lines(0, 0, 0, 0);
        tick(3);
        expect_bit("R5 set wins over clear", bus_status[7], 1'b1);
        clear_flags();

        cur_req = "R7";
        eop_irq_en = 1'b0;
        pulse(1, 1, 1, 0, MIN);
        expect_bit("R7 flag set with enable off", bus_status[7], 1'b1);
        expect_bit("R7 no irq with enable off", irq, 1'b0);
        eop_irq_en = 1'b1;
        tick(3);
        expect_bit("R7 late enable raises no irq", irq, 1'b0);
        clear_flags();
        pulse(1, 1, 1, 0, MIN);
        expect_bit("R7 irq set when enabled", irq, 1'b1);
        clear_flags();
        expect_bit("R7 irq cleared", irq, 1'b0);

        cur_req = "R8";
        other_irq_in = 1'b1;
        tick(1);
        expect_bit("R8 other cause drives irq", irq, 1'b1);
        expect_bit("R8 bit4 follows irq", bus_status[4], 1'b1);
        other_irq_in = 1'b0;
        tick(1);
        expect_bit("R8 irq drops with other cause", bus_status[4], 1'b0);

        cur_req = "R9";
        drq_in = 1; parity_err_in = 0; phase_match_in = 1; busy_err_in = 0; atn_in = 1; ack_in = 0;
        tick(1);
        expect_bit("R9 pattern A", bus_status == 8'b0100_1010, 1'b1);
        drq_in = 0; parity_err_in = 1; phase_match_in = 0; busy_err_in = 1; atn_in = 0; ack_in = 1;
        tick(1);
        expect_bit("R9 pattern B", bus_status == 8'b0010_0101, 1'b1);

        cur_req = "R1";
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(2);
        finish_run();
    end
endmodule